// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out where an instruction's operand comes from for an 8-bit accumulator machine with a 16-bit address space. The decoder supplies an addressing-mode code and the bytes that follow the opcode. The register file supplies the two index registers, the stack pointer and the program counter. From these the block produces exactly one of three results:
- an immediate operand value;
- a 16-bit effective address;
- a flag saying the instruction takes no operand.

The block also reports how many operand bytes the mode consumes. For 16-bit data accesses it gives the address of the second byte as well. The most significant byte sits at the effective address M and the least significant byte at M+1.

Each request is a single-cycle strobe on `inValid`. The result is registered and appears with `outValid` on the following cycle. When no request is made, the outputs hold their last values. Operand byte 0 is the first byte after the opcode, and byte 1 is the second.

Top module: `operand_addr_gen`

## Requirements
- R1: Mode codes 0 (inherent), 6 and 7 (reserved) give noOperand=1, isImm=0, addrValid=0, secondValid=0, opLen=0 and zero on immValue, effAddr and secondAddr.
- R2: Mode 1 (immediate) gives isImm=1, addrValid=0 and secondValid=0. With wideAccess=0, immValue is {0x00, byte0} and opLen is 1. With wideAccess=1, immValue is {byte0, byte1} and opLen is 2.
- R3: Mode 2 (direct) gives effAddr={0x00, byte0} and opLen=1, so it reaches only 0x0000 to 0x00FF.
- R4: Mode 3 (extended) gives effAddr={byte0, byte1}, with byte0 as the high byte, and opLen=2.
- R5: Mode 4 (short indexed) gives effAddr = base + sign-extended byte0, with opLen=1. baseSel picks the base: 0 is X, 1 is Y, 2 is SP, 3 is PC.
- R6: Mode 5 (long indexed) gives effAddr = base + {byte0, byte1}, with opLen=2 and the same base selection as R5.
- R7: All address sums, including the second-byte address, wrap modulo 65536.
- R8: For an address mode with wideAccess=1, secondValid=1 and secondAddr=effAddr+1. With wideAccess=0, secondValid=0 and secondAddr=0.
- R9: Results appear one cycle after an inValid strobe, with outValid high for that cycle only. Without a strobe, outValid is 0 and all result outputs hold.
- R10: After reset, outValid=0, noOperand=1 and all other result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request strobe |
| mode | input | 3 | Addressing-mode code |
| wideAccess | input | 1 | 16-bit operand access |
| baseSel | input | 2 | Index base select |
| opByte0 | input | 8 | First operand byte |
| opByte1 | input | 8 | Second operand byte |
| regX | input | 16 | Index register X |
| regY | input | 16 | Index register Y |
| regSp | input | 16 | Stack pointer |
| regPc | input | 16 | Program counter |
| outValid | output | 1 | Result valid |
| noOperand | output | 1 | Instruction takes no operand |
| isImm | output | 1 | Result is an immediate value |
| addrValid | output | 1 | Result is an effective address |
| immValue | output | 16 | Immediate operand value |
| effAddr | output | 16 | Effective address (MSB of a word) |
| secondValid | output | 1 | Second byte address valid |
| secondAddr | output | 16 | Address of the second (LSB) byte |
| opLen | output | 2 | Operand bytes consumed |

## Verification
Every result is due exactly one clock after the edge that captures the `inValid` strobe. The bench drives each request on a falling edge. It compares all outputs on the next falling edge, which is after the single register stage has loaded. A further falling edge with no strobe confirms that `outValid` has dropped and that every result output has held its value. The bench sweeps all mode codes, both access widths, all four bases and every value of the short offset. Expected values come from plain arithmetic in the bench.

// File: rtl/oag_pkg.sv
package oag_pkg;
  localparam int LEN_W = 2;

  typedef enum logic [2:0] {
    MODE_INH   = 3'd0,
    MODE_IMM   = 3'd1,
    MODE_DIR   = 3'd2,
    MODE_EXT   = 3'd3,
    MODE_IDX8  = 3'd4,
    MODE_IDX16 = 3'd5
  } addrMode_e;

  typedef struct packed {
    logic             selImm;
    logic             selAddr;
    logic             immWide;
    logic             zeroPage;
    logic             useIndex;
    logic             wideOffset;
    logic             pairAccess;
    logic [LEN_W-1:0] opLen;
  } ctrlStrobes_t;
endpackage

// File: rtl/oag_ctrl.sv
module oag_ctrl
  import oag_pkg::*;
(
  input  logic [2:0]   mode,
  input  logic         wideAccess,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    case (mode)
      MODE_IMM: begin
        strobes.selImm  = 1'b1;
        strobes.immWide = wideAccess;
        strobes.opLen   = wideAccess ? 2'd2 : 2'd1;
      end
      MODE_DIR: begin
        strobes.selAddr    = 1'b1;
        strobes.zeroPage   = 1'b1;
        strobes.pairAccess = wideAccess;
        strobes.opLen      = 2'd1;
      end
      MODE_EXT: begin
        strobes.selAddr    = 1'b1;
        strobes.pairAccess = wideAccess;
        strobes.opLen      = 2'd2;
      end
      MODE_IDX8: begin
        strobes.selAddr    = 1'b1;
        strobes.useIndex   = 1'b1;
        strobes.pairAccess = wideAccess;
        strobes.opLen      = 2'd1;
      end
      MODE_IDX16: begin
        strobes.selAddr    = 1'b1;
        strobes.useIndex   = 1'b1;
        strobes.wideOffset = 1'b1;
        strobes.pairAccess = wideAccess;
        strobes.opLen      = 2'd2;
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/oag_datapath.sv
module oag_datapath
  import oag_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NUM_BASE = 4,
  localparam int ADDR_W = 2 * BYTE_W,
  localparam int SEL_W = $clog2(NUM_BASE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  ctrlStrobes_t      strobes,
  input  logic [SEL_W-1:0]  baseSel,
  input  logic [BYTE_W-1:0] opByte0,
  input  logic [BYTE_W-1:0] opByte1,
  input  logic [ADDR_W-1:0] baseRegs [NUM_BASE],
  output logic              outValid,
  output logic              noOperand,
  output logic              isImm,
  output logic              addrValid,
  output logic [ADDR_W-1:0] immValue,
  output logic [ADDR_W-1:0] effAddr,
  output logic              secondValid,
  output logic [ADDR_W-1:0] secondAddr,
  output logic [LEN_W-1:0]  opLen
);
  logic [ADDR_W-1:0] baseVal;
  logic [ADDR_W-1:0] offsetExt;
  logic [ADDR_W-1:0] indexSum;
  logic [ADDR_W-1:0] rawAddr;
  logic [ADDR_W-1:0] rawImm;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] wordOperand;

  assign wordOperand = {opByte0, opByte1};
  assign baseVal     = baseRegs[baseSel];

  always_comb begin
    if (strobes.wideOffset) offsetExt = wordOperand;
    else                    offsetExt = {{BYTE_W{opByte0[BYTE_W-1]}}, opByte0};
  end

  assign indexSum = baseVal + offsetExt;

  always_comb begin
    if (strobes.useIndex)      rawAddr = indexSum;
    else if (strobes.zeroPage) rawAddr = {{BYTE_W{1'b0}}, opByte0};
    else                       rawAddr = wordOperand;
  end

  assign rawImm   = strobes.immWide ? wordOperand : {{BYTE_W{1'b0}}, opByte0};
  assign nextAddr = rawAddr + {{(ADDR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      noOperand   <= 1'b1;
      isImm       <= 1'b0;
      addrValid   <= 1'b0;
      immValue    <= '0;
      effAddr     <= '0;
      secondValid <= 1'b0;
      secondAddr  <= '0;
      opLen       <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        noOperand   <= ~(strobes.selImm | strobes.selAddr);
        isImm       <= strobes.selImm;
        addrValid   <= strobes.selAddr;
        immValue    <= strobes.selImm ? rawImm : '0;
        effAddr     <= strobes.selAddr ? rawAddr : '0;
        secondValid <= strobes.pairAccess;
        secondAddr  <= strobes.pairAccess ? nextAddr : '0;
        opLen       <= strobes.opLen;
      end
    end
  end

  // Exactly one result kind is reported (R1, R2, R3)
  assert_one_kind_R1: assert property (@(posedge clk) disable iff (!rstN)
    $countones({noOperand, isImm, addrValid}) == 1);
  assert_no_operand_len_R1: assert property (@(posedge clk) disable iff (!rstN)
    noOperand |-> (opLen == '0 && effAddr == '0 && immValue == '0));
  assert_imm_no_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    isImm |-> (!secondValid && effAddr == '0));
  assert_pair_needs_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    secondValid |-> addrValid);
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(effAddr) && $stable(immValue) && $stable(secondAddr)));
endmodule

// File: rtl/operand_addr_gen.sv
module operand_addr_gen
  import oag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [2:0]  mode,
  input  logic        wideAccess,
  input  logic [1:0]  baseSel,
  input  logic [7:0]  opByte0,
  input  logic [7:0]  opByte1,
  input  logic [15:0] regX,
  input  logic [15:0] regY,
  input  logic [15:0] regSp,
  input  logic [15:0] regPc,
  output logic        outValid,
  output logic        noOperand,
  output logic        isImm,
  output logic        addrValid,
  output logic [15:0] immValue,
  output logic [15:0] effAddr,
  output logic        secondValid,
  output logic [15:0] secondAddr,
  output logic [1:0]  opLen
);
  ctrlStrobes_t strobes;
  logic [15:0]  baseRegs [4];

  assign baseRegs[0] = regX;
  assign baseRegs[1] = regY;
  assign baseRegs[2] = regSp;
  assign baseRegs[3] = regPc;

  oag_ctrl ctrl_i (
    .mode       (mode),
    .wideAccess (wideAccess),
    .strobes    (strobes)
  );

  oag_datapath #(.BYTE_W(8), .NUM_BASE(4)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .strobes     (strobes),
    .baseSel     (baseSel),
    .opByte0     (opByte0),
    .opByte1     (opByte1),
    .baseRegs    (baseRegs),
    .outValid    (outValid),
    .noOperand   (noOperand),
    .isImm       (isImm),
    .addrValid   (addrValid),
    .immValue    (immValue),
    .effAddr     (effAddr),
    .secondValid (secondValid),
    .secondAddr  (secondAddr),
    .opLen       (opLen)
  );
endmodule

// File: tb/operand_addr_gen_tb_top.sv
`timescale 1ns/1ps
module operand_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  mode = '0;
  logic        wideAccess = 1'b0;
  logic [1:0]  baseSel = '0;
  logic [7:0]  opByte0 = '0;
  logic [7:0]  opByte1 = '0;
  logic [15:0] regX = 16'h5000;
  logic [15:0] regY = 16'hFFF0;
  logic [15:0] regSp = 16'h0005;
  logic [15:0] regPc = 16'h2100;
  logic        outValid, noOperand, isImm, addrValid, secondValid;
  logic [15:0] immValue, effAddr, secondAddr;
  logic [1:0]  opLen;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  operand_addr_gen dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .wideAccess(wideAccess), .baseSel(baseSel), .opByte0(opByte0),
    .opByte1(opByte1), .regX(regX), .regY(regY), .regSp(regSp), .regPc(regPc),
    .outValid(outValid), .noOperand(noOperand), .isImm(isImm),
    .addrValid(addrValid), .immValue(immValue), .effAddr(effAddr),
    .secondValid(secondValid), .secondAddr(secondAddr), .opLen(opLen)
  );

  function automatic logic [55:0] gotVec();
    return {noOperand, isImm, addrValid, secondValid, 2'b00, opLen,
            immValue, effAddr, secondAddr};
  endfunction

  task automatic check(input string req, input logic [55:0] got, input logic [55:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h (mode=%0d wide=%0b sel=%0d b0=%h b1=%h)",
               req, got, exp, mode, wideAccess, baseSel, opByte0, opByte1);
    end
  endtask

  task automatic runOne(input logic [2:0] m, input logic w, input logic [1:0] s,
                        input logic [7:0] b0, input logic [7:0] b1);
    logic [15:0] base, ea, imm, sa;
    logic        nop, im, av, sv;
    logic [1:0]  len;
    string       req;
    logic [55:0] snap;
    @(negedge clk);
    mode = m; wideAccess = w; baseSel = s; opByte0 = b0; opByte1 = b1; inValid = 1'b1;
    case (s)
      2'd0: base = regX;
      2'd1: base = regY;
      2'd2: base = regSp;
      default: base = regPc;
    endcase
    nop = 0; im = 0; av = 0; sv = 0; len = 0; ea = 0; imm = 0; sa = 0;
    case (m)
      3'd1: begin req = "R2"; im = 1; len = w ? 2 : 1; imm = w ? {b0, b1} : {8'h00, b0}; end
      3'd2: begin req = "R3"; av = 1; len = 1; ea = {8'h00, b0}; end
      3'd3: begin req = "R4"; av = 1; len = 2; ea = {b0, b1}; end
      3'd4: begin req = "R5"; av = 1; len = 1;
                  ea = 16'((32'(base) + 32'($signed(b0)) + 32'h10000) % 32'h10000); end
      3'd5: begin req = "R6"; av = 1; len = 2;
                  ea = 16'((32'(base) + 32'({b0, b1})) % 32'h10000); end
      default: begin req = "R1"; nop = 1; end
    endcase
    if (av && w) begin sv = 1; sa = 16'((32'(ea) + 1) % 32'h10000); end
    @(negedge clk);
    inValid = 1'b0;
    checks++;
    if (outValid !== 1'b1) begin
      fails++;
      $display("FAIL R9 outValid got=%b expected=1", outValid);
    end
    check(req, gotVec(), {nop, im, av, sv, 2'b00, len, imm, ea, sa});
    if (sv) check("R8", {40'h0, secondAddr}, {40'h0, sa});
    snap = gotVec();
    mode = ~m; opByte0 = ~b0; opByte1 = ~b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      fails++;
      $display("FAIL R9 outValid idle got=%b expected=0", outValid);
    end
    check("R9", gotVec(), snap);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got=hang expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 0 || noOperand !== 1 || isImm !== 0 || addrValid !== 0 ||
        secondValid !== 0 || opLen !== 0 || immValue !== 0 || effAddr !== 0 || secondAddr !== 0) begin
      fails++;
      $display("FAIL R10 reset state got=%h expected=%h", gotVec(), {4'b1000, 52'h0});
    end
    rstN = 1'b1;

    // Named cases: R5 Y-based 0x5000+0x4C, R3 direct 0xE3, R4 extended 0x20B4
    regY = 16'h5000;
    runOne(3'd4, 1'b0, 2'd1, 8'h4C, 8'h00);
    runOne(3'd2, 1'b0, 2'd0, 8'hE3, 8'h00);
    runOne(3'd3, 1'b1, 2'd0, 8'h20, 8'hB4);
    // R7 wrap cases
    regY = 16'hFFF0;
    runOne(3'd4, 1'b1, 2'd1, 8'h7F, 8'h00);
    runOne(3'd4, 1'b0, 2'd2, 8'h80, 8'h00);
    runOne(3'd3, 1'b1, 2'd0, 8'hFF, 8'hFF);
    runOne(3'd5, 1'b1, 2'd1, 8'h00, 8'h20);

    // Broad sweep over every mode code, width and base
    foreach (regX[i]) begin end
    for (int m = 0; m < 8; m++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 4; s++)
          for (int k = 0; k < 5; k++)
            for (int j = 0; j < 3; j++) begin
              logic [7:0] b0v, b1v;
              case (k) 0: b0v = 8'h00; 1: b0v = 8'h7F; 2: b0v = 8'h80; 3: b0v = 8'hFF; default: b0v = 8'hE3; endcase
              case (j) 0: b1v = 8'h00; 1: b1v = 8'hB4; default: b1v = 8'hFF; endcase
              runOne(3'(m), 1'(w), 2'(s), b0v, b1v);
            end

    // Exhaustive short offsets on every base (R5, R7, R8)
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 256; v++)
        runOne(3'd4, 1'(v & 1), 2'(s), 8'(v), 8'h5A);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule